// File: doc/BRIEF.md
# Pulse-Swallow Programmable Feedback Divider

This block divides a fast clock by an integer ratio N that can be set in steps of one. It sits in the feedback path of a frequency synthesizer, where its output pulse train goes to a phase-frequency detector. Only a small dual-modulus stage, dividing by 4 or 5, runs at every edge of the fast clock. Slower program and swallow counters decide how many of its cycles use each modulus.

The requested ratio is split into a program count B = N div 4 and a swallow count A = N mod 4. In each output period the prescaler divides by 5 for its first A cycles and by 4 for the remaining B - A cycles, which gives 5A + 4(B - A) = N input cycles. The split needs B >= A, so any request below 12 is raised to 12 and a flag marks the substitution. A new ratio is taken only at the end of an output period, so a change can never shorten or stretch the period in progress.

Top module: `pswallow_fbdiv`

## Requirements
- R1: While `rst_n` is low, `fb_pulse` and `n_clamped` are low. Reset is released through a two-stage synchronizer. The first period after reset uses the minimum ratio of 12, so the first pulse is high after the 14th rising edge that follows the rise of `rst_n`.
- R2: For any ratio N with 12 <= N <= 2^N_W - 1, successive rising edges of `fb_pulse` are exactly N input clock edges apart.
- R3: `fb_pulse` is high for exactly one input clock cycle per period.
- R4: All four swallow counts work. The ratios 12 to 19 each give their own exact spacing, which covers N mod 4 = 0, 1, 2 and 3 with both B = A and B > A.
- R5: A requested ratio below 12 is used as 12. `n_clamped` goes high at the same edge as the pulse that starts such a period, and it stays constant until the next pulse. It returns low once a ratio of 12 or more is taken.
- R6: `div_n` is sampled only in the last input cycle of a period, the cycle just before `fb_pulse` rises. A change during a period does not affect that period's length. It sets the length of the following period.
- R7: The largest ratio allowed by the width, 2^N_W - 1 (1023 by default), gives an exact period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_n | input | N_W | Requested division ratio |
| fb_pulse | output | 1 | One-cycle pulse at the end of each period |
| n_clamped | output | 1 | The current period uses a ratio raised to the minimum |

## Verification
The hardest case to reach from the ports is a ratio change that lands in the middle of a period. The only sign of when the new value is taken is the length of the period after it. The stimulus first lines up with a pulse and waits until a known ratio is in effect. It then changes `div_n` a few cycles into the next period and measures two consecutive spacings: the first must keep the old ratio and the second must show the new one. Clamped requests are reached the same way, with the flag checked in the cycle of the pulse that starts the clamped period.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;
  // prescaler base modulus (power of two); high modulus is PSC_MOD+1
  localparam int unsigned PSC_MOD   = 4;
  localparam int unsigned PSC_LOG   = $clog2(PSC_MOD);
  // smallest ratio for which program count >= swallow count always holds
  localparam int unsigned MIN_RATIO = PSC_MOD * (PSC_MOD - 1);
endpackage

// File: rtl/pswallow_rst_sync.sv
module pswallow_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_b
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_b = sync_q[STAGES-1];
endmodule

// File: rtl/pswallow_ratio_loader.sv
module pswallow_ratio_loader
  import pswallow_pkg::*;
#(
  parameter int unsigned N_W   = 10,
  localparam int unsigned PRG_W = N_W - PSC_LOG
) (
  input  logic             clk,
  input  logic             rst_b,
  input  logic [N_W-1:0]   div_n,
  input  logic             take,
  output logic [PRG_W-1:0] ld_prog,
  output logic [PSC_LOG-1:0] ld_swl,
  output logic             clamped
);
  logic           below_min;
  logic [N_W-1:0] eff_n;
  logic           clamped_d;

  always_comb begin
    below_min = (div_n < N_W'(MIN_RATIO));
    eff_n     = below_min ? N_W'(MIN_RATIO) : div_n;
    ld_prog   = eff_n[N_W-1:PSC_LOG];
    ld_swl    = eff_n[PSC_LOG-1:0];
    clamped_d = take ? below_min : clamped;
  end

  always_ff @(posedge clk or negedge rst_b) begin
    if (!rst_b) clamped <= 1'b0;
    else        clamped <= clamped_d;
  end
endmodule

// File: rtl/pswallow_prescaler.sv
module pswallow_prescaler
  import pswallow_pkg::*;
(
  input  logic clk,
  input  logic rst_b,
  input  logic mod_hi,
  output logic pre_tc
);
  localparam int unsigned PC_W = $clog2(PSC_MOD + 1);

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_d;
  logic [PC_W-1:0] last_cnt;

  always_comb begin
    last_cnt = mod_hi ? PC_W'(PSC_MOD) : PC_W'(PSC_MOD - 1);
    pre_tc   = (pc_q == last_cnt);
    pc_d     = pre_tc ? '0 : pc_q + PC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_b) begin
    if (!rst_b) pc_q <= '0;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/pswallow_swallow_ctr.sv
module pswallow_swallow_ctr
  import pswallow_pkg::*;
#(
  parameter int unsigned PRG_W = 8
) (
  input  logic               clk,
  input  logic               rst_b,
  input  logic               pre_tc,
  input  logic [PRG_W-1:0]   ld_prog,
  input  logic [PSC_LOG-1:0] ld_swl,
  output logic               mod_hi,
  output logic               period_end
);
  logic [PRG_W-1:0]   prog_q, prog_d;
  logic [PSC_LOG-1:0] swl_q,  swl_d;
  logic               cnt_en;

  always_comb begin
    mod_hi     = (swl_q != '0);
    period_end = pre_tc && (prog_q == PRG_W'(1));
    cnt_en     = pre_tc;
    prog_d     = prog_q;
    swl_d      = swl_q;
    if (period_end) begin
      prog_d = ld_prog;
      swl_d  = ld_swl;
    end else if (cnt_en) begin
      prog_d = prog_q - PRG_W'(1);
      if (mod_hi) swl_d = swl_q - PSC_LOG'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_b) begin
    if (!rst_b) begin
      prog_q <= PRG_W'(MIN_RATIO / PSC_MOD);
      swl_q  <= PSC_LOG'(MIN_RATIO % PSC_MOD);
    end else begin
      prog_q <= prog_d;
      swl_q  <= swl_d;
    end
  end
endmodule

// File: rtl/pswallow_fbdiv.sv
module pswallow_fbdiv
  import pswallow_pkg::*;
#(
  parameter int unsigned N_W = 10
) (
  input  logic           clk_in,
  input  logic           rst_n,
  input  logic [N_W-1:0] div_n,
  output logic           fb_pulse,
  output logic           n_clamped
);
  localparam int unsigned PRG_W = N_W - PSC_LOG;

  logic               rst_b;
  logic               pre_tc;
  logic               mod_hi;
  logic               period_end;
  logic [PRG_W-1:0]   ld_prog;
  logic [PSC_LOG-1:0] ld_swl;
  logic               pulse_d;

  pswallow_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk_in),
    .rst_n (rst_n),
    .rst_b (rst_b)
  );

  pswallow_ratio_loader #(.N_W(N_W)) u_load (
    .clk     (clk_in),
    .rst_b   (rst_b),
    .div_n   (div_n),
    .take    (period_end),
    .ld_prog (ld_prog),
    .ld_swl  (ld_swl),
    .clamped (n_clamped)
  );

  pswallow_prescaler u_pre (
    .clk    (clk_in),
    .rst_b  (rst_b),
    .mod_hi (mod_hi),
    .pre_tc (pre_tc)
  );

  pswallow_swallow_ctr #(.PRG_W(PRG_W)) u_swl (
    .clk        (clk_in),
    .rst_b      (rst_b),
    .pre_tc     (pre_tc),
    .ld_prog    (ld_prog),
    .ld_swl     (ld_swl),
    .mod_hi     (mod_hi),
    .period_end (period_end)
  );

  always_comb pulse_d = period_end;

  always_ff @(posedge clk_in or negedge rst_b) begin
    if (!rst_b) fb_pulse <= 1'b0;
    else        fb_pulse <= pulse_d;
  end
endmodule

// File: rtl/pswallow_fbdiv_chk.sv
module pswallow_fbdiv_chk
  import pswallow_pkg::*;
#(
  parameter int unsigned N_W = 10
) (
  input logic clk,
  input logic rst_b,
  input logic fb_pulse,
  input logic n_clamped,
  input logic pre_tc,
  input logic mod_hi
);
  localparam int unsigned GAP_W = N_W + 1;
  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_b) begin
    if (!rst_b)                gap_q <= '0;
    else if (fb_pulse)         gap_q <= GAP_W'(1);
    else if (gap_q != '1)      gap_q <= gap_q + GAP_W'(1);
  end

  // R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_b)
    fb_pulse |=> !fb_pulse);

  // R2
  gap_floor_chk: assert property (@(posedge clk) disable iff (!rst_b)
    fb_pulse |-> (gap_q >= GAP_W'(MIN_RATIO)));

  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_b)
    !fb_pulse |-> $stable(n_clamped));

  // R4
  prescale_tc_chk: assert property (@(posedge clk) disable iff (!rst_b)
    pre_tc |=> !pre_tc);

  // R4
  swallow_end_chk: assert property (@(posedge clk) disable iff (!rst_b)
    $fell(mod_hi) |-> $past(pre_tc));
endmodule

bind pswallow_fbdiv pswallow_fbdiv_chk #(.N_W(N_W)) u_chk (
  .clk       (clk_in),
  .rst_b     (rst_b),
  .fb_pulse  (fb_pulse),
  .n_clamped (n_clamped),
  .pre_tc    (pre_tc),
  .mod_hi    (mod_hi)
);

// File: tb/pswallow_fbdiv_bench.sv
module pswallow_fbdiv_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_W = 10;

  logic           clk_in = 1'b0;
  logic           rst_n  = 1'b0;
  logic [N_W-1:0] div_n  = '0;
  logic           fb_pulse;
  logic           n_clamped;

  int total = 0;
  int bad   = 0;
  int edge_cnt = 0;

  always #(CLK_PERIOD/2) clk_in = ~clk_in;
  always @(posedge clk_in) edge_cnt <= edge_cnt + 1;

  pswallow_fbdiv #(.N_W(N_W)) u_pswallow_fbdiv (
    .clk_in    (clk_in),
    .rst_n     (rst_n),
    .div_n     (div_n),
    .fb_pulse  (fb_pulse),
    .n_clamped (n_clamped)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic next_pulse(output int idx);
    idx = -1;
    for (int w = 0; w < 4000; w++) begin
      @(negedge clk_in);
      if (fb_pulse) begin
        idx = edge_cnt;
        break;
      end
    end
    if (idx < 0) check("pulse timeout", 0, 1);
  endtask

  // measure the period that follows after applying n at a period start
  task automatic measure(input int n, input string req, input int exp);
    int p0, p1, p2;
    next_pulse(p0);
    div_n = N_W'(n);
    next_pulse(p1);
    next_pulse(p2);
    check(req, p2 - p1, exp);
    @(negedge clk_in);
    check("R3 width", int'(fb_pulse), 0);
  endtask

  task automatic t_reset();
    int base, p1, p2;
    div_n = N_W'(30);
    repeat (3) @(negedge clk_in);
    check("R1 pulse in reset", int'(fb_pulse), 0);
    check("R1 flag in reset", int'(n_clamped), 0);
    rst_n = 1'b1;
    base = edge_cnt;
    next_pulse(p1);
    check("R1 first pulse edge", p1 - base, 14);
    check("R1 flag after reset", int'(n_clamped), 0);
    next_pulse(p2);
    check("R1 second period", p2 - p1, 30);
  endtask

  task automatic t_sweep();
    for (int n = 12; n <= 19; n++) measure(n, "R4 ratio", n);
    measure(23, "R2 ratio 23", 23);
    measure(50, "R2 ratio 50", 50);
    measure(101, "R2 ratio 101", 101);
  endtask

  task automatic t_clamp();
    int p0, p1, p2;
    next_pulse(p0);
    div_n = N_W'(5);
    next_pulse(p1);
    check("R5 flag set", int'(n_clamped), 1);
    next_pulse(p2);
    check("R5 clamped ratio", p2 - p1, 12);
    check("R5 flag held", int'(n_clamped), 1);
    measure(0, "R5 zero clamped", 12);
    div_n = N_W'(13);
    next_pulse(p1);
    check("R5 flag cleared", int'(n_clamped), 0);
    next_pulse(p2);
    check("R5 after clear", p2 - p1, 13);
  endtask

  task automatic t_midchange();
    int pa, pb, pc, pd;
    next_pulse(pa);
    div_n = N_W'(20);
    next_pulse(pb);
    repeat (5) @(negedge clk_in);
    div_n = N_W'(33);
    next_pulse(pc);
    check("R6 current period kept", pc - pb, 20);
    next_pulse(pd);
    check("R6 next period new", pd - pc, 33);
  endtask

  task automatic t_max();
    measure(1023, "R7 max ratio", 1023);
  endtask

  initial begin
    t_reset();
    t_sweep();
    t_clamp();
    t_midchange();
    t_max();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_in);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule